// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog built around a down-counter. Software programs a timeout value and turns the counter on. If software then stops servicing the watchdog, the block first raises an interrupt. If that interrupt is still pending when the counter runs out a second time, the block raises a system reset request. Two control bits change this. A single-stage mode skips the interrupt and requests reset on the first expiry. A reset-inhibit bit keeps the interrupt stage but never raises the reset request.

The block uses two clocks. Software reaches a small word-addressed register set on the bus clock. The counter runs on a separate core clock. Configuration moves from the bus domain to the core domain through a request/acknowledge handshake. The interrupt-clear command crosses as a toggle. The live count comes back to the bus domain through a second handshake, and its holding register stays frozen while the far side samples it. A key register protects the load and control registers, so a stray write cannot turn the watchdog off.

Register map (3-bit word address):

- 0: timeout value
- 1: control, where bit 0 enables counting, bit 1 selects single-stage mode and bit 2 inhibits reset
- 2: key, which reads 1 when unlocked
- 3: interrupt clear, written with any value
- 4: count readback

Top module: `wdg_top`

## Requirements
- R1: After both resets, `wdt_irq` and `wdt_rst_req` are low, the key register reads 0 (locked), and the count readback (address 4) shows the reset timeout value 32'h0000_FFFF.
- R2: While locked, writes to address 0 and address 1 are ignored. Writing 32'h5A5A_C3C3 to address 2 unlocks them. Writing any other value to address 2 locks them again.
- R3: While control bit 0 is 0, the counter holds the programmed timeout value and both outputs stay low.
- R4: While enabled, the counter decrements once per core clock. Its value as read at address 4 falls over time.
- R5: In two-stage mode (bit 1 = 0), the counter reaching zero raises `wdt_irq` and reloads the timeout value.
- R6: In two-stage mode, a second expiry while `wdt_irq` is still high raises `wdt_rst_req`.
- R7: With bit 2 set, expiries never raise `wdt_rst_req`, and the interrupt behaviour is unchanged.
- R8: In single-stage mode (bit 1 = 1), the first expiry raises `wdt_rst_req` and `wdt_irq` stays low.
- R9: A write to address 3 drops `wdt_irq` and reloads the counter, so servicing in time prevents the reset request.
- R10: Once raised, `wdt_rst_req` stays high, even if counting is disabled, until the core-domain reset is applied.
- R11: Address 4 returns a count value that was captured coherently in the core domain. It never exceeds the programmed timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| core_clk | input | 1 | Counting clock |
| core_rst_n | input | 1 | Core-domain asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_irq | output | 1 | Interrupt, core domain |
| wdt_rst_req | output | 1 | Sticky reset request, core domain |

## Verification
The bench targets four corner cases:

- **Missing interrupt stage.** It samples mid-way between the first and second expiry. A design that skipped the interrupt stage would already show a reset request at that point. A design that failed to reload would never expire a second time.
- **Mode bits.** It checks that the reset-inhibit and single-stage bits each change only their own output. A design that mixed them up would raise the interrupt in single-stage mode or fire reset under inhibit.
- **Service and sticky request.** It services the watchdog, then stops, then turns counting off. A design without a sticky request would drop `wdt_rst_req` once counting stopped.
- **Lock.** Writes sent while locked must leave the readback at its reset value and leave the counter idle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 3;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_KEY   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ICLR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_SINGLE = 1;
  localparam int unsigned CB_RDIS   = 2;
endpackage

// File: rtl/wdg_xfer.sv
// Continuous request/acknowledge transfer of a word between clock domains.
module wdg_xfer #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic [W-1:0] s_data,
  input  logic         d_clk,
  input  logic         d_rst_n,
  output logic [W-1:0] d_data
);
  logic         req_q, ack_s1, ack_s2, busy;
  logic [W-1:0] hold_q;
  logic         req_s1, req_s2, ack_q;

  assign busy = (ack_s2 != req_q);

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= INIT;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_q;
      ack_s2 <= ack_s1;
      if (!busy) begin
        hold_q <= s_data;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      ack_q  <= 1'b0;
      d_data <= INIT;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      if (req_s2 != ack_q) begin
        d_data <= hold_q;
        ack_q  <= req_s2;
      end
    end
  end

  // R11: holding word is frozen while the far side may sample it
  a_r11_hold_stable: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    busy |=> $stable(hold_q));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEY = 32'h5A5A_C3C3,
  parameter logic [W-1:0] RST_LOAD = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt_rb,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      load_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              clr_tgl
);
  logic              unlock_q, unlock_n, clr_n, wr_hit;
  logic [W-1:0]      load_n;
  logic [CTRL_W-1:0] ctrl_n;

  assign wr_hit = sel && wr;

  always_comb begin
    unlock_n = unlock_q;
    load_n   = load_q;
    ctrl_n   = ctrl_q;
    clr_n    = clr_tgl;
    if (wr_hit) begin
      case (addr)
        A_KEY:  unlock_n = (wdata == KEY);
        A_LOAD: if (unlock_q) load_n = wdata;
        A_CTRL: if (unlock_q) ctrl_n = wdata[CTRL_W-1:0];
        A_ICLR: clr_n = ~clr_tgl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      load_q   <= RST_LOAD;
      ctrl_q   <= '0;
      clr_tgl  <= 1'b0;
    end else begin
      unlock_q <= unlock_n;
      load_q   <= load_n;
      ctrl_q   <= ctrl_n;
      clr_tgl  <= clr_n;
    end
  end

  always_comb begin
    case (addr)
      A_LOAD:  rdata = load_q;
      A_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
      A_KEY:   rdata = {{(W-1){1'b0}}, unlock_q};
      A_COUNT: rdata = cnt_rb;
      default: rdata = '0;
    endcase
  end

  // R2: a locked block ignores configuration writes
  a_r2_lock_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !unlock_q && addr != A_KEY) |=> ($stable(load_q) && $stable(ctrl_q)));
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_LOAD = 32'h0000_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] load,
  input  logic         en,
  input  logic         single,
  input  logic         rdis,
  input  logic         clr_tgl,
  output logic [W-1:0] cnt_q,
  output logic         irq_q,
  output logic         rst_q
);
  logic [2:0]   clr_s;
  logic         clr;
  logic [W-1:0] cnt_n;
  logic         irq_n, rst_n_nxt;

  assign clr = clr_s[1] ^ clr_s[2];

  always_comb begin
    cnt_n     = cnt_q;
    irq_n     = irq_q;
    rst_n_nxt = rst_q;
    if (!en || clr) begin
      cnt_n = load;
      irq_n = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_n = load;
      if (single || irq_q) begin
        if (!rdis) rst_n_nxt = 1'b1;
      end else begin
        irq_n = 1'b1;
      end
    end else begin
      cnt_n = cnt_q - 1'b1;
    end
    if (single) irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_s <= '0;
      cnt_q <= RST_LOAD;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      clr_s <= {clr_s[1:0], clr_tgl};
      cnt_q <= cnt_n;
      irq_q <= irq_n;
      rst_q <= rst_n_nxt;
    end
  end

  // R3: idle counter holds the timeout and outputs stay quiet
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!irq_q && cnt_q == $past(load)));
  // R5: interrupt rises together with a reload
  a_r5_irq_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (cnt_q == $past(load)));
  // R6: reset request only after a pending interrupt or in single-stage mode
  a_r6_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(irq_q) || $past(single)));
  // R7: inhibit blocks the reset request
  a_r7_rdis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rdis |=> !$rose(rst_q));
  // R8: single-stage mode never raises the interrupt
  a_r8_single_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    single |=> !irq_q);
  // R10: reset request is sticky
  a_r10_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEY = 32'h5A5A_C3C3,
  parameter logic [W-1:0] RST_LOAD = 32'h0000_FFFF
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  localparam int unsigned CFG_W = W + CTRL_W;

  logic [1:0]        brs, crs;
  logic              b_rst, c_rst;
  logic [W-1:0]      load_b, cnt_c, cnt_b;
  logic [CTRL_W-1:0] ctrl_b;
  logic              clr_tgl;
  logic [CFG_W-1:0]  cfg_c;

  // asynchronous assertion, synchronous release per domain
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) brs <= '0;
    else            brs <= {brs[0], 1'b1};
  end
  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) crs <= '0;
    else             crs <= {crs[0], 1'b1};
  end
  assign b_rst = brs[1];
  assign c_rst = crs[1];

  wdg_regs #(.W(W), .KEY(KEY), .RST_LOAD(RST_LOAD)) u_regs (
    .clk(bus_clk), .rst_n(b_rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cnt_rb(cnt_b), .rdata(bus_rdata), .load_q(load_b),
    .ctrl_q(ctrl_b), .clr_tgl(clr_tgl)
  );

  wdg_xfer #(.W(CFG_W), .INIT({RST_LOAD, {CTRL_W{1'b0}}})) u_cfg_x (
    .s_clk(bus_clk), .s_rst_n(b_rst), .s_data({load_b, ctrl_b}),
    .d_clk(core_clk), .d_rst_n(c_rst), .d_data(cfg_c)
  );

  wdg_core #(.W(W), .RST_LOAD(RST_LOAD)) u_core (
    .clk(core_clk), .rst_n(c_rst), .load(cfg_c[CFG_W-1:CTRL_W]),
    .en(cfg_c[CB_EN]), .single(cfg_c[CB_SINGLE]), .rdis(cfg_c[CB_RDIS]),
    .clr_tgl(clr_tgl), .cnt_q(cnt_c), .irq_q(wdt_irq), .rst_q(wdt_rst_req)
  );

  wdg_xfer #(.W(W), .INIT(RST_LOAD)) u_rb_x (
    .s_clk(core_clk), .s_rst_n(c_rst), .s_data(cnt_c),
    .d_clk(bus_clk), .d_rst_n(b_rst), .d_data(cnt_b)
  );
endmodule

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  logic        bclk = 0, cclk = 0, brst_n = 0, crst_n = 0;
  logic        sel = 0, wr = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq, rreq;
  int total = 0, bad = 0;

  localparam logic [31:0] KEY = 32'h5A5A_C3C3;
  localparam logic [31:0] RLD = 32'h0000_FFFF;

  always #10 bclk = ~bclk;  // 50 MHz bus clock
  always #17 cclk = ~cclk;  // core clock

  wdg_top dut (
    .bus_clk(bclk), .bus_rst_n(brst_n), .core_clk(cclk), .core_rst_n(crst_n),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .wdt_irq(irq), .wdt_rst_req(rreq)
  );

  // {tag[3:0], ctrl[2:0], wait[15:0], exp_irq, exp_rst}; timeout = 40 core cycles
  localparam logic [24:0] TV [7] = '{
    {4'd4, 3'b001, 16'd35,  1'b0, 1'b0},  // R4 counting, no expiry yet
    {4'd5, 3'b001, 16'd110, 1'b1, 1'b0},  // R5 first expiry
    {4'd6, 3'b001, 16'd200, 1'b1, 1'b1},  // R6 second expiry
    {4'd7, 3'b101, 16'd200, 1'b1, 1'b0},  // R7 reset inhibited
    {4'd8, 3'b011, 16'd110, 1'b0, 1'b1},  // R8 single-stage
    {4'd8, 3'b011, 16'd35,  1'b0, 1'b0},  // R8 before expiry
    {4'd3, 3'b000, 16'd200, 1'b0, 1'b0}   // R3 disabled
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitb(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge bclk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge bclk); sel = 0; wr = 0;
  endtask

  task automatic br(input logic [2:0] a, output logic [31:0] d);
    @(negedge bclk); addr = a; #1 d = rdata;
  endtask

  task automatic reset_all();
    brst_n = 0; crst_n = 0; waitb(5);
    brst_n = 1; crst_n = 1; waitb(15);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    // R1 reset state
    reset_all();
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst_req", {31'b0, rreq}, 0);
    br(3'd2, v); check("R1 lock state", v, 0);
    br(3'd4, v); check("R1 readback", v, RLD);

    // R2 locked writes ignored
    bw(3'd0, 32'd77); bw(3'd1, 32'd1); waitb(50);
    br(3'd0, v); check("R2 load locked", v, RLD);
    br(3'd4, v); check("R2 count idle", v, RLD);
    bw(3'd2, KEY); br(3'd2, v); check("R2 unlocked", v, 1);
    bw(3'd2, 32'd1); br(3'd2, v); check("R2 relocked", v, 0);

    // vector table
    for (int i = 0; i < 7; i++) begin
      logic [3:0] tg; logic [2:0] c; logic [15:0] w; logic ei, er;
      {tg, c, w, ei, er} = TV[i];
      reset_all();
      bw(3'd2, KEY); bw(3'd0, 32'd40); waitb(20); bw(3'd1, {29'b0, c});
      waitb(w);
      check($sformatf("R%0d irq vec%0d", tg, i), {31'b0, irq}, {31'b0, ei});
      check($sformatf("R%0d rst vec%0d", tg, i), {31'b0, rreq}, {31'b0, er});
    end

    // R3 / R11 / R4 readback
    reset_all();
    bw(3'd2, KEY); bw(3'd0, 32'd1000); waitb(20);
    br(3'd4, v); check("R3 holds load", v, 32'd1000);
    bw(3'd1, 32'd1); waitb(30);
    br(3'd4, a); waitb(50); br(3'd4, b);
    check("R11 within timeout", {31'b0, (a < 32'd1000)}, 1);
    check("R4 decrement rate", {31'b0, ((a - b) >= 20) && ((a - b) <= 40)}, 1);

    // R9 service, then R6 after neglect, then R10 sticky
    reset_all();
    bw(3'd2, KEY); bw(3'd0, 32'd40); waitb(20); bw(3'd1, 32'd1);
    waitb(110); check("R9 irq before clear", {31'b0, irq}, 1);
    bw(3'd3, 32'd0); waitb(10);
    check("R9 irq cleared", {31'b0, irq}, 0);
    waitb(40); check("R9 no reset after service", {31'b0, rreq}, 0);
    waitb(150); check("R6 reset after neglect", {31'b0, rreq}, 1);
    bw(3'd1, 32'd0); waitb(30);
    check("R10 sticky when disabled", {31'b0, rreq}, 1);
    crst_n = 0; waitb(5); crst_n = 1; waitb(10);
    check("R10 cleared by core reset", {31'b0, rreq}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule